// File: doc/BRIEF.md
# Smart Card UART Interrupt Controller

This block is the interrupt logic of a UART-style smart card port. The host writes a three-bit enable register and a FIFO control byte; the serial engine reports receive errors, the receive buffer fill level and transmit-buffer-empty events as strobes and levels; a card detector supplies an asynchronous presence line. The block merges all of these into a single interrupt request and a read-only status byte that tells the host which source to serve first.

Coded sources follow the classic UART priority scheme: receive errors first, then receive data ready, then transmit buffer empty. A card insertion or removal raises a separate toggle flag. That flag always requests an interrupt and is shown next to the live presence level. The serial shifter, baud generation, FIFO storage and address decode sit outside the block.

Top module: `scard_irq_ctrl`

## Requirements
- R1: After reset the enable register and FIFO control register are zero, all source flags are clear, `irq` is 0 and `isr_data` reads 8'h01.
- R2: A strobe on any of `err_silent`, `err_nostop`, `err_parity` or `err_overrun` sets the receive-error flag at that clock edge. `lsr_rd` clears the flag. A new error in the same cycle as `lsr_rd` keeps it set.
- R3: With FIFOs disabled (FIFO control bit 0 = 0), the receive-ready flag is 1 whenever `rx_level` is nonzero. The flag is registered from `rx_level`.
- R4: With FIFOs enabled, the receive-ready flag is 1 when `rx_level` is at least the trigger level. The trigger field is FIFO control bits 7:6, and the codes 00, 01, 10 and 11 select 1, 4, 8 and 14 bytes.
- R5: `tx_empty_evt` sets the transmit-empty flag only while `dir_in` is 0. While `dir_in` is 1 the flag is held clear. `tx_write` clears the flag.
- R6: A status read (`isr_rd`) clears the transmit-empty flag only if the code shown at that read is 001. A read at any other code leaves the flag unchanged.
- R7: The enable bits are: bit 2 for receive errors, bit 1 for transmit empty and bit 0 for receive ready. The code is 011 for an enabled receive error, else 010 for enabled receive ready, else 001 for enabled transmit empty, else 000. Disabled sources show no code and raise no interrupt.
- R8: The `isr_data` fields are:
  - bit 0: active-low pending, 0 when the code is nonzero or the toggle flag is set
  - bits 3:1: the code
  - bit 4: the toggle flag
  - bit 5: the synchronized presence level
  - bits 7 and 6: both copy FIFO control bit 0
- R9: `card_present` passes through two synchronizer flops. Either edge of the synchronized level sets the toggle flag one clock later. `isr_rd` clears the flag, but a new edge in the same cycle keeps it set.
- R10: `irq` is a register loaded with (code != 000) OR (toggle flag). It therefore follows the status byte by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 3 | Enable value: bit2 errors, bit1 tx empty, bit0 rx ready |
| fcr_wr | input | 1 | Write strobe for the FIFO control register |
| fcr_wdata | input | 8 | Bit0 FIFO enable, bits 7:6 trigger code |
| err_silent | input | 1 | Silent-byte error strobe |
| err_nostop | input | 1 | Missing stop bit strobe |
| err_parity | input | 1 | Parity error strobe |
| err_overrun | input | 1 | Overrun strobe |
| lsr_rd | input | 1 | Line status read strobe, clears the error flag |
| rx_level | input | LVL_W | Receive byte count |
| tx_empty_evt | input | 1 | Transmit buffer became empty |
| tx_write | input | 1 | Host loaded the transmit buffer |
| dir_in | input | 1 | Transfer direction, 0 = output to card |
| isr_rd | input | 1 | Status register read strobe |
| card_present | input | 1 | Asynchronous card presence line |
| isr_data | output | 8 | Status register value |
| irq | output | 1 | Interrupt request |

## Verification
Strobes and `rx_level` sampled at edge k appear in `isr_data` just after edge k. `irq` reflects them after edge k+1. A change on `card_present` appears in bit 5 after the second edge and in the toggle flag after the third. The bench drives inputs at the falling edge. It steps a cycle-accurate model at each rising edge and compares both outputs at the next falling edge, so every check lands in the cycle these latencies fix.

// File: rtl/scard_irq_pkg.sv
package scard_irq_pkg;
  localparam logic [2:0] CODE_NONE = 3'b000;
  localparam logic [2:0] CODE_TXE  = 3'b001;
  localparam logic [2:0] CODE_RDR  = 3'b010;
  localparam logic [2:0] CODE_ERR  = 3'b011;

  // trigger code to byte count
  function automatic int unsigned trig_bytes(input logic [1:0] t);
    case (t)
      2'b00:   trig_bytes = 1;
      2'b01:   trig_bytes = 4;
      2'b10:   trig_bytes = 8;
      default: trig_bytes = 14;
    endcase
  endfunction
endpackage

// File: rtl/scard_presence_sync.sv
module scard_presence_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic card_in,
  input  logic clr,
  output logic live,
  output logic tog_edge,
  output logic tog_flag
);
  logic s1_q, s2_q, prev_q, flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      s1_q   <= card_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (tog_edge)  flag_q <= 1'b1;
      else if (clr)  flag_q <= 1'b0;
    end
  end

  assign live     = s2_q;
  assign tog_edge = s2_q ^ prev_q;
  assign tog_flag = flag_q;

  assert_toggle_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tog_edge |=> tog_flag);
  assert_toggle_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !tog_edge) |=> !tog_flag);
endmodule

// File: rtl/scard_src_flags.sv
module scard_src_flags #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       err_stb,
  input  logic             lsr_rd,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             fifo_en,
  input  logic [1:0]       trig,
  input  logic             tx_empty_evt,
  input  logic             tx_write,
  input  logic             dir_in,
  input  logic             isr_rd,
  input  logic             code_is_tx,
  output logic             err_flag,
  output logic             rdr_flag,
  output logic             txe_flag
);
  import scard_irq_pkg::*;

  logic err_q, rdr_q, txe_q;
  logic any_err, rdr_cond, txe_clr;
  logic [LVL_W:0] thr;

  assign any_err  = |err_stb;
  assign thr      = (LVL_W+1)'(trig_bytes(trig));
  assign rdr_cond = fifo_en ? ({1'b0, rx_level} >= thr) : (rx_level != '0);
  assign txe_clr  = tx_write | (isr_rd & code_is_tx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      rdr_q <= 1'b0;
      txe_q <= 1'b0;
    end else begin
      if (any_err)     err_q <= 1'b1;
      else if (lsr_rd) err_q <= 1'b0;
      rdr_q <= rdr_cond;
      if (dir_in)            txe_q <= 1'b0;
      else if (tx_empty_evt) txe_q <= 1'b1;
      else if (txe_clr)      txe_q <= 1'b0;
    end
  end

  assign err_flag = err_q;
  assign rdr_flag = rdr_q;
  assign txe_flag = txe_q;

  assert_err_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |=> err_flag);
  assert_err_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !any_err) |=> !err_flag);
  assert_rdr_nofifo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rx_level != '0) |=> rdr_flag);
  assert_tx_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dir_in |=> !txe_flag);
  assert_tx_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (txe_flag && !dir_in && !tx_write && !code_is_tx) |=> txe_flag);
endmodule

// File: rtl/scard_irq_prio.sv
module scard_irq_prio (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ier,
  input  logic       err_flag,
  input  logic       rdr_flag,
  input  logic       txe_flag,
  input  logic       tog_flag,
  output logic [2:0] code,
  output logic       pend_n,
  output logic       irq
);
  import scard_irq_pkg::*;

  logic irq_q, want;

  always_comb begin
    if (err_flag && ier[2])      code = CODE_ERR;
    else if (rdr_flag && ier[0]) code = CODE_RDR;
    else if (txe_flag && ier[1]) code = CODE_TXE;
    else                         code = CODE_NONE;
  end

  assign want   = (code != CODE_NONE) | tog_flag;
  assign pend_n = ~want;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= want;
  end
  assign irq = irq_q;

  assert_err_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && ier[2]) |-> code == CODE_ERR);
  assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 3'b000) |-> code == CODE_NONE);
  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (code != CODE_NONE) |=> irq);
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_NONE && !tog_flag) |=> !irq);
endmodule

// File: rtl/scard_irq_ctrl.sv
module scard_irq_ctrl #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [2:0]       ier_wdata,
  input  logic             fcr_wr,
  input  logic [7:0]       fcr_wdata,
  input  logic             err_silent,
  input  logic             err_nostop,
  input  logic             err_parity,
  input  logic             err_overrun,
  input  logic             lsr_rd,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_empty_evt,
  input  logic             tx_write,
  input  logic             dir_in,
  input  logic             isr_rd,
  input  logic             card_present,
  output logic [7:0]       isr_data,
  output logic             irq
);
  import scard_irq_pkg::*;

  logic [2:0] ier_q;
  logic       fifo_en_q;
  logic [1:0] trig_q;
  logic       err_flag, rdr_flag, txe_flag;
  logic       live, tog_edge, tog_flag;
  logic [2:0] code;
  logic       pend_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q     <= 3'b000;
      fifo_en_q <= 1'b0;
      trig_q    <= 2'b00;
    end else begin
      if (ier_wr) ier_q <= ier_wdata;
      if (fcr_wr) begin
        fifo_en_q <= fcr_wdata[0];
        trig_q    <= fcr_wdata[7:6];
      end
    end
  end

  scard_presence_sync u_pres (
    .clk      (clk),
    .rst_n    (rst_n),
    .card_in  (card_present),
    .clr      (isr_rd),
    .live     (live),
    .tog_edge (tog_edge),
    .tog_flag (tog_flag)
  );

  scard_src_flags #(.LVL_W(LVL_W)) u_src (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_stb      ({err_silent, err_nostop, err_parity, err_overrun}),
    .lsr_rd       (lsr_rd),
    .rx_level     (rx_level),
    .fifo_en      (fifo_en_q),
    .trig         (trig_q),
    .tx_empty_evt (tx_empty_evt),
    .tx_write     (tx_write),
    .dir_in       (dir_in),
    .isr_rd       (isr_rd),
    .code_is_tx   (code == CODE_TXE),
    .err_flag     (err_flag),
    .rdr_flag     (rdr_flag),
    .txe_flag     (txe_flag)
  );

  scard_irq_prio u_prio (
    .clk      (clk),
    .rst_n    (rst_n),
    .ier      (ier_q),
    .err_flag (err_flag),
    .rdr_flag (rdr_flag),
    .txe_flag (txe_flag),
    .tog_flag (tog_flag),
    .code     (code),
    .pend_n   (pend_n),
    .irq      (irq)
  );

  assign isr_data = {fifo_en_q, fifo_en_q, live, tog_flag, code, pend_n};

  assert_pend_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(isr_data[0]) == 1'b0);
  assert_fifo_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
    isr_data[7] == isr_data[6]);
endmodule

// File: tb/scard_irq_ctrl_tb_top.sv
module scard_irq_ctrl_tb_top;
  localparam int LVL_W = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic ier_wr, fcr_wr, lsr_rd, tx_empty_evt, tx_write, dir_in, isr_rd, card_present;
  logic [2:0] ier_wdata;
  logic [7:0] fcr_wdata;
  logic err_silent, err_nostop, err_parity, err_overrun;
  logic [LVL_W-1:0] rx_level;
  logic [7:0] isr_data;
  logic irq;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  logic [2:0] m_ier;
  logic m_fen;
  logic [1:0] m_trig;
  logic m_err, m_rdr, m_txe, m_tog, m_irq;
  logic m_s1, m_s2, m_prev;

  always #5 clk = ~clk;

  scard_irq_ctrl #(.LVL_W(LVL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .err_silent(err_silent),
    .err_nostop(err_nostop), .err_parity(err_parity), .err_overrun(err_overrun),
    .lsr_rd(lsr_rd), .rx_level(rx_level), .tx_empty_evt(tx_empty_evt),
    .tx_write(tx_write), .dir_in(dir_in), .isr_rd(isr_rd),
    .card_present(card_present), .isr_data(isr_data), .irq(irq)
  );

  function automatic int level_for(input logic [1:0] t);
    int table_v [4] = '{1, 4, 8, 14};
    return table_v[t];
  endfunction

  function automatic logic [2:0] m_code();
    if (m_err && m_ier[2]) return 3'd3;
    if (m_rdr && m_ier[0]) return 3'd2;
    if (m_txe && m_ier[1]) return 3'd1;
    return 3'd0;
  endfunction

  function automatic logic [7:0] m_isr();
    logic [2:0] c;
    c = m_code();
    return {m_fen, m_fen, m_s2, m_tog, c, ~((c != 3'd0) | m_tog)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ier = 0; m_fen = 0; m_trig = 0; m_err = 0; m_rdr = 0; m_txe = 0;
    m_tog = 0; m_irq = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
  endtask

  task automatic idle_inputs();
    ier_wr = 0; fcr_wr = 0; lsr_rd = 0; tx_empty_evt = 0; tx_write = 0;
    isr_rd = 0; err_silent = 0; err_nostop = 0; err_parity = 0; err_overrun = 0;
  endtask

  // advance one clock (inputs already driven), update model, compare at negedge
  task automatic step(input string tag);
    logic [2:0] oc;
    logic oany, edge_v, thr_ok;
    oc = m_code();
    oany = (oc != 0) | m_tog;
    edge_v = m_s2 ^ m_prev;
    thr_ok = m_fen ? (int'(rx_level) >= level_for(m_trig)) : (rx_level != 0);
    @(posedge clk);
    m_prev = m_s2; m_s2 = m_s1; m_s1 = card_present;
    if (edge_v) m_tog = 1; else if (isr_rd) m_tog = 0;
    if (err_silent | err_nostop | err_parity | err_overrun) m_err = 1;
    else if (lsr_rd) m_err = 0;
    m_rdr = thr_ok;
    if (dir_in) m_txe = 0;
    else if (tx_empty_evt) m_txe = 1;
    else if (tx_write | (isr_rd & (oc == 3'd1))) m_txe = 0;
    if (ier_wr) m_ier = ier_wdata;
    if (fcr_wr) begin m_fen = fcr_wdata[0]; m_trig = fcr_wdata[7:6]; end
    m_irq = oany;
    @(negedge clk);
    check({tag, " isr"}, 32'(isr_data), 32'(m_isr()));
    check({tag, " irq"}, 32'(irq), 32'(m_irq));
    idle_inputs();
  endtask

  task automatic wr_ier(input logic [2:0] v);
    ier_wr = 1; ier_wdata = v; step("R7 ier write");
  endtask

  task automatic wr_fcr(input logic [1:0] t, input logic en);
    fcr_wr = 1; fcr_wdata = {t, 5'b0, en}; step("R4 fcr write");
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    ier_wdata = 0; fcr_wdata = 0; rx_level = 0; dir_in = 0; card_present = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    check("R1 reset isr", 32'(isr_data), 32'h01);
    check("R1 reset irq", 32'(irq), 32'h0);
    step("R1 idle");

    // R2 each error source, R7 priority
    wr_ier(3'b111);
    err_parity = 1; step("R2 parity");
    check("R2 code err", 32'(isr_data[3:1]), 32'd3);
    step("R10 irq next");
    check("R10 irq up", 32'(irq), 32'd1);
    lsr_rd = 1; step("R2 clear");
    err_silent = 1; step("R2 silent");
    err_nostop = 1; lsr_rd = 1; step("R2 set wins");
    check("R2 set over clear", 32'(isr_data[3:1]), 32'd3);
    lsr_rd = 1; step("R2 clear2");
    err_overrun = 1; step("R2 overrun");
    // R7: rx ready under error
    rx_level = 1; step("R7 both");
    check("R7 err over rdr", 32'(isr_data[3:1]), 32'd3);
    lsr_rd = 1; step("R7 rdr shows");
    check("R7 rdr next", 32'(isr_data[3:1]), 32'd2);

    // R3 no fifo
    rx_level = 0; step("R3 empty");
    check("R3 empty code", 32'(isr_data[3:1]), 32'd0);

    // R4 thresholds
    for (int t = 0; t < 4; t++) begin
      wr_fcr(2'(t), 1'b1);
      rx_level = LVL_W'(level_for(2'(t)) - 1); step("R4 below");
      check("R4 below thr", 32'(isr_data[3:1]), 32'd0);
      rx_level = LVL_W'(level_for(2'(t))); step("R4 at");
      check("R4 at thr", 32'(isr_data[3:1]), 32'd2);
    end
    check("R8 fifo bits", 32'(isr_data[7:6]), 32'd3);
    rx_level = 0; wr_fcr(2'b00, 1'b0);

    // R5 tx empty and direction
    dir_in = 1; tx_empty_evt = 1; step("R5 dir ignored");
    check("R5 dir in ignored", 32'(isr_data[3:1]), 32'd0);
    dir_in = 0; tx_empty_evt = 1; step("R5 set");
    check("R5 tx code", 32'(isr_data[3:1]), 32'd1);
    tx_write = 1; step("R5 write clr");
    // R6 read clears only when code is tx
    tx_empty_evt = 1; step("R6 set");
    rx_level = 2; step("R6 rdr over tx");
    isr_rd = 1; step("R6 read at rdr");
    rx_level = 0; step("R6 tx remains");
    check("R6 tx kept", 32'(isr_data[3:1]), 32'd1);
    isr_rd = 1; step("R6 read at tx");
    check("R6 tx cleared", 32'(isr_data[3:1]), 32'd0);

    // R9 presence toggle, masked sources
    wr_ier(3'b000);
    card_present = 1; step("R9 p1"); step("R9 p2");
    check("R8 live bit", 32'(isr_data[5]), 32'd1);
    step("R9 p3");
    check("R9 toggle flag", 32'(isr_data[4]), 32'd1);
    step("R9 irq");
    check("R9 irq from toggle", 32'(irq), 32'd1);
    isr_rd = 1; step("R9 clear");
    check("R9 flag cleared", 32'(isr_data[4]), 32'd0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      ier_wr       = ($urandom % 20) == 0; ier_wdata = 3'($urandom);
      fcr_wr       = ($urandom % 30) == 0; fcr_wdata = 8'($urandom);
      err_silent   = ($urandom % 40) == 0;
      err_nostop   = ($urandom % 40) == 0;
      err_parity   = ($urandom % 40) == 0;
      err_overrun  = ($urandom % 40) == 0;
      lsr_rd       = ($urandom % 8) == 0;
      tx_empty_evt = ($urandom % 10) == 0;
      tx_write     = ($urandom % 12) == 0;
      isr_rd       = ($urandom % 6) == 0;
      if (($urandom % 6) == 0) rx_level = LVL_W'($urandom % 17);
      if (($urandom % 25) == 0) dir_in = ~dir_in;
      if (($urandom % 30) == 0) card_present = ~card_present;
      step("R10 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule